// File: doc/BRIEF.md
# Per-Processor Dual-Mode Timer

This block is the timer that sits beside one processor. It has two personalities, and an external mode bit chooses between them. In counter mode it is an interval counter. It counts up in steps of 0x200 on each tick enable and compares against a programmable limit. When the count reaches the limit it raises an interrupt to its processor and starts again from zero. A limit of zero makes it a free-running counter with no match. In user mode the same storage becomes a wide 63-bit counter, read and preloaded as an upper word and a lower word. Software starts and stops it through a status register, and it never interrupts.

The register window is 16 bytes of 32-bit words, and the meaning of each offset depends on the mode. The mode register itself lives outside the block. This block watches the mode input on every clock and applies the side effects of a switch once, at the edge where the input changes.

Top module: `pcpu_timer`

## Requirements
- R1: After reset the block is in counter mode and running. The count is 0, the limit is 0, the reached flag is clear and `irq` is low.
- R2: Counter mode, counting and match.
  - Writing offset 0x0 loads the limit from bits 30:9 (all other bits are dropped), resets the count to 0 and deasserts `irq`.
  - Each tick adds 0x200 to the count. Offset 0x4 reads the count in bits 30:9, bits 8:0 as zero and the reached flag in bit 31.
  - When the count reaches a non-zero limit it wraps to 0, sets reached and asserts `irq`.
- R3: In counter mode, a read of offset 0x0 returns the limit in bits 30:9 with the other bits zero. That read clears reached and deasserts `irq`.
- R4: Counter mode, free-run and limit-only writes.
  - With a limit of 0 the counter runs freely, with no reached flag and no interrupt.
  - Writing offset 0x8 changes the limit without resetting the count.
  - A match against the new limit occurs when the incremented count is equal to or greater than that limit.
- R5: Offset 0xC reads the running state in bit 0. In counter mode the block is always running, and writes to 0xC have no effect.
- R6: On a switch from counter mode to user mode the block does four things: it deasserts `irq`, clears running, clears the whole 63-bit count and clears reached.
- R7: User mode, preload.
  - Writing offset 0x0 loads the upper word from bits 30:0.
  - Writing offset 0x4 loads lower-word bits 31:9.
  - Either write clears reached, and counting continues from the combined value.
  - Offset 0x0 reads `{reached, upper[30:0]}`. Offset 0x4 reads the lower word with bits 8:0 zero.
- R8: User mode, run control. A write to 0xC with bit 0 set starts the counter, and a write with bit 0 clear stops it. While running, each tick adds 0x200 and carries from the lower word into the upper word. While stopped, ticks leave the count unchanged.
- R9: User mode, terminal count.
  - When the count would reach 0x7FFFFFFF_FFFFFE00, it wraps to 0 and sets reached.
  - Reading offset 0x0 in user mode does not clear reached.
  - `irq` is never asserted in user mode.
- R10: On a switch from user mode to counter mode the block sets running to 1 and the limit to 0 (free-run). It also restarts the count from 0 with reached clear.
- R11: Writes with no meaning in the current mode are ignored: offset 0x4 in counter mode, and offset 0x8 in user mode.
- R12: A mode change is acted on once, at the clock edge where `userMode` differs from its registered value. A bus write or tick presented in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count enable, one count step per asserted cycle |
| userMode | input | 1 | Mode select from the central mode register: 1 = user mode, 0 = counter mode |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe; read side effects take place at the next edge |
| addr | input | 4 | Byte offset of the register word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from `addr` while `rdEn` is high, else 0 |
| irq | output | 1 | Interrupt to the local processor |

## Verification
The hardest state to reach from the ports is the user-mode terminal count. Its 63-bit width could never be ticked through. The bench instead stops the counter, preloads the upper word to all ones and the lower word to two steps below the top, then starts it and ticks twice. A second awkward case is a mode flip that lands in the same cycle as a bus write and a tick. The bench drives all three together, with a pending interrupt from counter mode, and then reads every register to show that only the flip took effect.

// File: rtl/pcpu_timer_pkg.sv
package pcpu_timer_pkg;

  localparam int ADDR_W = 4;

  // Word offsets in the 16-byte window
  localparam logic [ADDR_W-1:0] OFF_TOP  = 4'h0;  // limit / upper word
  localparam logic [ADDR_W-1:0] OFF_CNT  = 4'h4;  // count / lower word
  localparam logic [ADDR_W-1:0] OFF_LKEEP = 4'h8; // limit without count reset
  localparam logic [ADDR_W-1:0] OFF_RUN  = 4'hC;  // running status

  typedef struct packed {
    logic isUser;       // registered mode
    logic enterUser;    // counter -> user at this edge
    logic enterCounter; // user -> counter at this edge
    logic tick;         // advance the count at this edge
    logic ldLimitRst;   // counter mode: load limit, reset count
    logic ldLimitKeep;  // counter mode: load limit only
    logic ldHigh;       // user mode: load upper word
    logic ldLow;        // user mode: load lower word
    logic runSet;       // user mode: start
    logic runClr;       // user mode: stop
    logic ackReached;   // counter mode: limit read clears reached / irq
  } tmrStrobes_t;

endpackage

// File: rtl/pcpu_timer_ctrl.sv
module pcpu_timer_ctrl
  import pcpu_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              userMode,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrBit0,
  input  logic              running,
  output tmrStrobes_t       strb
);

  logic modeQ;
  logic modeFlip;
  logic busOk;

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= 1'b0;
    else       modeQ <= userMode;
  end

  assign modeFlip = (userMode != modeQ);
  assign busOk    = !modeFlip;

  always_comb begin
    strb              = '0;
    strb.isUser       = modeQ;
    strb.enterUser    = modeFlip && userMode;
    strb.enterCounter = modeFlip && !userMode;
    strb.tick         = busOk && tickEn && running;
    if (busOk && wrEn) begin
      if (modeQ) begin
        strb.ldHigh = (addr == OFF_TOP);
        strb.ldLow  = (addr == OFF_CNT);
        strb.runSet = (addr == OFF_RUN) && wrBit0 && !running;
        strb.runClr = (addr == OFF_RUN) && !wrBit0 && running;
      end else begin
        strb.ldLimitRst  = (addr == OFF_TOP);
        strb.ldLimitKeep = (addr == OFF_LKEEP);
      end
    end
    strb.ackReached = busOk && rdEn && !modeQ && (addr == OFF_TOP);
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.enterUser, strb.enterCounter, strb.ldLimitRst, strb.ldLimitKeep,
              strb.ldHigh, strb.ldLow, strb.runSet, strb.runClr})); // R12
  AST_FLIP_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    strb.enterUser |=> (strb.isUser && !strb.enterUser)); // R12

endmodule

// File: rtl/pcpu_timer_datapath.sv
module pcpu_timer_datapath
  import pcpu_timer_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int UNIT_LSB = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobes_t       strb,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              running,
  output logic              irq
);

  localparam int SHORT_W = WORD_W - 1 - UNIT_LSB;     // counter-mode count bits
  localparam int LOW_W   = WORD_W - UNIT_LSB;         // user lower-word count bits
  localparam int HIGH_W  = WORD_W - 1;                // user upper-word bits
  localparam int LONG_W  = LOW_W + HIGH_W;            // whole user count

  logic [LONG_W-1:0]  cntQ, cntD, cntInc;
  logic [SHORT_W-1:0] limQ, limD, wrapPt;
  logic [SHORT_W:0]   shortInc;
  logic               reachedQ, reachedD;
  logic               runQ, runD;
  logic               irqQ, irqD;
  logic               shortHit, longHit, loadHit;

  assign cntInc   = cntQ + 1'b1;
  assign shortInc = {1'b0, cntQ[SHORT_W-1:0]} + 1'b1;
  assign wrapPt   = (limQ == '0) ? '1 : limQ;
  assign shortHit = (shortInc >= {1'b0, wrapPt});
  assign longHit  = (cntInc == '1);
  assign loadHit  = strb.ldLimitRst || strb.ldHigh || strb.ldLow;

  always_comb begin
    cntD     = cntQ;
    limD     = limQ;
    reachedD = reachedQ;
    runD     = runQ;
    irqD     = irqQ;
    if (strb.enterUser) begin
      cntD     = '0;
      limD     = '0;
      reachedD = 1'b0;
      runD     = 1'b0;
      irqD     = 1'b0;
    end else if (strb.enterCounter) begin
      cntD     = '0;
      limD     = '0;
      reachedD = 1'b0;
      runD     = 1'b1;
      irqD     = 1'b0;
    end else begin
      if (strb.ldLimitRst) begin
        limD = wrData[WORD_W-2:UNIT_LSB];
        cntD = '0;
        irqD = 1'b0;
      end
      if (strb.ldLimitKeep) limD = wrData[WORD_W-2:UNIT_LSB];
      if (strb.ldHigh) begin
        cntD[LONG_W-1:LOW_W] = wrData[HIGH_W-1:0];
        reachedD = 1'b0;
      end
      if (strb.ldLow) begin
        cntD[LOW_W-1:0] = wrData[WORD_W-1:UNIT_LSB];
        reachedD = 1'b0;
      end
      if (strb.runSet) runD = 1'b1;
      if (strb.runClr) runD = 1'b0;
      if (strb.ackReached) begin
        reachedD = 1'b0;
        irqD     = 1'b0;
      end
      if (strb.tick && !loadHit) begin
        if (strb.isUser) begin
          if (longHit) begin
            cntD     = '0;
            reachedD = 1'b1;
          end else begin
            cntD = cntInc;
          end
        end else if (shortHit) begin
          cntD = '0;
          if (limQ != '0) begin
            reachedD = 1'b1;
            irqD     = 1'b1;
          end
        end else begin
          cntD = LONG_W'(shortInc[SHORT_W-1:0]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ     <= '0;
      limQ     <= '0;
      reachedQ <= 1'b0;
      runQ     <= 1'b1;
      irqQ     <= 1'b0;
    end else begin
      cntQ     <= cntD;
      limQ     <= limD;
      reachedQ <= reachedD;
      runQ     <= runD;
      irqQ     <= irqD;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (addr)
        OFF_TOP: rdData = strb.isUser ? {reachedQ, cntQ[LONG_W-1:LOW_W]}
                                      : {1'b0, limQ, {UNIT_LSB{1'b0}}};
        OFF_CNT: rdData = strb.isUser ? {cntQ[LOW_W-1:0], {UNIT_LSB{1'b0}}}
                                      : {reachedQ, cntQ[SHORT_W-1:0], {UNIT_LSB{1'b0}}};
        OFF_RUN: rdData = {{(WORD_W-1){1'b0}}, runQ};
        default: rdData = '0;
      endcase
    end
  end

  assign running = runQ;
  assign irq     = irqQ;

  AST_USER_IRQ_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.isUser |-> !irqQ); // R9
  AST_COUNTER_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.isUser |-> runQ); // R5
  AST_ENTER_USER: assert property (@(posedge clk) disable iff (!rstN)
    strb.enterUser |=> (!runQ && cntQ == '0 && !reachedQ)); // R6
  AST_ENTER_COUNTER: assert property (@(posedge clk) disable iff (!rstN)
    strb.enterCounter |=> (runQ && limQ == '0 && cntQ == '0)); // R10
  AST_IRQ_FROM_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> $past(strb.tick && !strb.isUser)); // R2
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.isUser && !runQ && !strb.ldHigh && !strb.ldLow && !strb.enterCounter)
      |=> $stable(cntQ)); // R8

endmodule

// File: rtl/pcpu_timer.sv
module pcpu_timer
  import pcpu_timer_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int UNIT_LSB = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              userMode,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              irq
);

  tmrStrobes_t strb;
  logic        running;

  pcpu_timer_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .userMode (userMode),
    .tickEn   (tickEn),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .addr     (addr),
    .wrBit0   (wrData[0]),
    .running  (running),
    .strb     (strb)
  );

  pcpu_timer_datapath #(
    .WORD_W   (WORD_W),
    .UNIT_LSB (UNIT_LSB)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rdEn    (rdEn),
    .addr    (addr),
    .wrData  (wrData),
    .rdData  (rdData),
    .running (running),
    .irq     (irq)
  );

endmodule

// File: tb/pcpu_timer_tb.sv
`timescale 1ns/1ps
module pcpu_timer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        userMode = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  pcpu_timer u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .userMode(userMode),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_IRQ = 2'd3;
  localparam int NV = 33;
  // {op, addr, data, expected, requirement number}
  localparam logic [73:0] VECS [0:NV-1] = '{
    {OP_RD,  4'h4, 32'h0,        32'h0,        4'd1},  // R1 count 0
    {OP_RD,  4'h0, 32'h0,        32'h0,        4'd1},  // R1 limit 0
    {OP_RD,  4'hC, 32'h0,        32'h1,        4'd1},  // R1 running
    {OP_IRQ, 4'h0, 32'h0,        32'h0,        4'd1},  // R1 irq low
    {OP_WR,  4'h0, 32'h00000600, 32'h0,        4'd2},  // R2 limit = 3 steps
    {OP_TK,  4'h0, 32'd1,        32'h0,        4'd2},
    {OP_RD,  4'h4, 32'h0,        32'h200,      4'd2},  // R2
    {OP_TK,  4'h0, 32'd1,        32'h0,        4'd2},
    {OP_RD,  4'h4, 32'h0,        32'h400,      4'd2},  // R2
    {OP_TK,  4'h0, 32'd1,        32'h0,        4'd2},
    {OP_RD,  4'h4, 32'h0,        32'h80000000, 4'd2},  // R2 wrap + reached
    {OP_IRQ, 4'h0, 32'h0,        32'h1,        4'd2},  // R2 irq up
    {OP_RD,  4'h0, 32'h0,        32'h00000600, 4'd3},  // R3 limit read
    {OP_IRQ, 4'h0, 32'h0,        32'h0,        4'd3},  // R3 irq cleared
    {OP_RD,  4'h4, 32'h0,        32'h0,        4'd3},  // R3 reached cleared
    {OP_WR,  4'h4, 32'h12345678, 32'h0,        4'd11}, // R11 ignored
    {OP_RD,  4'h4, 32'h0,        32'h0,        4'd11},
    {OP_WR,  4'hC, 32'h0,        32'h0,        4'd5},  // R5 ignored
    {OP_RD,  4'hC, 32'h0,        32'h1,        4'd5},
    {OP_WR,  4'h0, 32'h0,        32'h0,        4'd4},  // R4 free-run
    {OP_TK,  4'h0, 32'd5,        32'h0,        4'd4},
    {OP_RD,  4'h4, 32'h0,        32'h00000A00, 4'd4},
    {OP_WR,  4'h8, 32'h00000E00, 32'h0,        4'd4},  // R4 limit 7, no reset
    {OP_RD,  4'h4, 32'h0,        32'h00000A00, 4'd4},
    {OP_TK,  4'h0, 32'd1,        32'h0,        4'd4},
    {OP_RD,  4'h4, 32'h0,        32'h00000C00, 4'd4},
    {OP_TK,  4'h0, 32'd1,        32'h0,        4'd4},
    {OP_IRQ, 4'h0, 32'h0,        32'h1,        4'd4},  // R4 match at new limit
    {OP_WR,  4'h0, 32'h800003FF, 32'h0,        4'd2},  // R2 masked limit = 1 step
    {OP_IRQ, 4'h0, 32'h0,        32'h0,        4'd2},  // R2 limit write drops irq
    {OP_RD,  4'h0, 32'h0,        32'h00000200, 4'd3},  // R3 masked read
    {OP_TK,  4'h0, 32'd1,        32'h0,        4'd2},
    {OP_IRQ, 4'h0, 32'h0,        32'h1,        4'd2}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr = a; rdEn = 1'b1;
    #2;
    check(tag, rdData, exp);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [3:0]  va;
      logic [31:0] vd, ve;
      string       tag;
      {op, va, vd, ve} = VECS[i][73:4];
      tag = $sformatf("R%0d vec%0d", VECS[i][3:0], i);
      case (op)
        OP_WR:   wr(va, vd);
        OP_RD:   rdChk(va, ve, tag);
        OP_TK:   ticks(int'(vd));
        default: check(tag, {31'b0, irq}, ve);
      endcase
    end

    // R12 / R6: mode flip together with a write and a tick
    userMode = 1'b1; addr = 4'h4; wrData = 32'hFFFFFE00; wrEn = 1'b1; tickEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tickEn = 1'b0;
    check("R6 irq dropped on entry to user", {31'b0, irq}, 32'h0);
    rdChk(4'hC, 32'h0, "R6 stopped on entry");
    rdChk(4'h0, 32'h0, "R6 upper word cleared");
    rdChk(4'h4, 32'h0, "R12 write in flip cycle ignored");

    // R8: ticks while stopped
    ticks(3);
    rdChk(4'h4, 32'h0, "R8 stopped count holds");

    // R7 / R9: preload near terminal count
    wr(4'h0, 32'hFFFFFFFF);
    rdChk(4'h0, 32'h7FFFFFFF, "R7 upper word load");
    wr(4'h4, 32'hFFFFFBFF);
    rdChk(4'h4, 32'hFFFFFA00, "R7 lower word load");
    wr(4'hC, 32'h1);
    rdChk(4'hC, 32'h1, "R8 started");
    ticks(1);
    rdChk(4'h4, 32'hFFFFFC00, "R8 one step");
    ticks(1);
    rdChk(4'h0, 32'h80000000, "R9 terminal wrap sets reached");
    rdChk(4'h0, 32'h80000000, "R9 read keeps reached");
    rdChk(4'h4, 32'h0, "R9 lower word wrapped");
    check("R9 no irq in user mode", {31'b0, irq}, 32'h0);

    // R7 / R8: reached cleared by load, carry into upper word
    wr(4'h0, 32'h5);
    wr(4'h4, 32'hFFFFFE00);
    rdChk(4'h0, 32'h5, "R7 load clears reached");
    ticks(1);
    rdChk(4'h0, 32'h6, "R8 carry into upper word");
    rdChk(4'h4, 32'h0, "R8 lower word rolls");
    ticks(2);
    wr(4'hC, 32'h0);
    rdChk(4'hC, 32'h0, "R8 stop");
    ticks(4);
    rdChk(4'h4, 32'h400, "R8 stopped holds");
    wr(4'h8, 32'h600);
    rdChk(4'h4, 32'h400, "R11 user write at 0x8 ignored");
    rdChk(4'h0, 32'h6, "R11 upper word unchanged");

    // R10: back to counter mode
    userMode = 1'b0;
    @(negedge clk);
    rdChk(4'hC, 32'h1, "R10 running on return");
    rdChk(4'h0, 32'h0, "R10 limit zero");
    rdChk(4'h4, 32'h0, "R10 count restarted");
    ticks(2);
    rdChk(4'h4, 32'h400, "R10 free-run counting");
    check("R10 no irq in free-run", {31'b0, irq}, 32'h0);

    done = 1'b1;
    finishRun();
  end

endmodule